// File: doc/BRIEF.md
# Serial Flash Sector Lock Command Front End

This block is the slave-side command front end of a serial NOR flash that handles the volatile per-sector protection bits. It receives SPI mode 0 traffic on a single data input, oversamples the serial clock and chip select in a fast system clock domain, and decodes four commands:
- set the write-enable latch
- clear the write-enable latch
- read status
- write one sector's lock register

It also holds the one-time-programmable control byte that decides whether a 64-byte OTP area may still be written. It exposes the current lock bits and the OTP state to the array controller as plain vectors.

A lock or OTP write frame is an opcode followed by a 24-bit address and one data byte, all MSB first. It takes effect only when all three of these hold:
- the write-enable latch was set by an earlier command;
- no erase, program or write cycle is running, as reported on the busy input;
- chip select rises exactly after the last data bit.

A successful write takes effect at once and consumes the latch.

Top module: `spiLockWriter`

## Requirements
- R1: After reset every write-lock and lock-down bit is 0, the write-enable latch is 0, the OTP control byte reads 0xFF and the OTP area is not read-only.
- R2: A frame of exactly 8 bits carrying 0x06 sets the write-enable latch and one carrying 0x04 clears it. Opcode 0x05 returns a status byte on the serial output, MSB first. In that byte bit 1 is the write-enable latch and bit 0 is the busy input, and the other bits are 0. Each bit changes after a falling serial-clock edge, and the byte is reloaded afresh every 8 bits.
- R3: A lock write (opcode 0xE5) selects the sector with address bits 20:16 and ignores all other address bits. Data bit 0 goes into that sector's write-lock bit and data bit 1 into its lock-down bit. Data bits 7:2 are ignored.
- R4: A lock or OTP write made while the write-enable latch is 0 changes nothing.
- R5: A lock or OTP write is carried out only if chip select rises after exactly 40 clock bits. With 39 or 41 bits it changes nothing and leaves the write-enable latch as it was.
- R6: A lock or OTP write that is carried out clears the write-enable latch.
- R7: A lock or OTP write made while the busy input is high at the chip-select rise changes nothing and leaves the write-enable latch set.
- R8: Once a sector's lock-down bit is 1, later lock writes to that sector leave both of its bits unchanged until reset. Such a write still clears the write-enable latch.
- R9: The OTP program opcode 0x42 uses the lock-write frame. Its data bits 3:0 AND into the OTP control nibble, so bits can only go from 1 to 0. Bits 7:4 of the control byte always read 1. The OTP area reports read-only when the nibble is 0.
- R10: A committed update reaches the output vectors within a few system clocks of the chip-select rise, with no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Serial clock, mode 0 |
| csNIn | input | 1 | Active-low chip select |
| mosiIn | input | 1 | Serial data input |
| busyIn | input | 1 | High while an erase, program or write cycle runs |
| misoOut | output | 1 | Serial status data output |
| writeLockVec | output | 32 | Write-lock bit per sector |
| lockDownVec | output | 32 | Lock-down bit per sector |
| otpCtrlOut | output | 8 | OTP control byte |
| otpLockedOut | output | 1 | OTP area is read-only |

## Verification
Some internal faults show up only when a write happens and nothing at the ports tells them apart:
- a bit counter that drifts by one;
- an opcode shifted into the wrong bit position;
- a stale write-enable latch.

For each of these, the first following frame either commits where it should not or is dropped where it should commit. The lock vectors then differ from the reference model a few system clocks after that chip-select rise. A wrong latch value also shows in the next status byte. A mis-decoded sector field moves a bit into the wrong lane of the vectors, and the first per-clock comparison after that frame settles catches it.

// File: rtl/spiLockPkg.sv
package spiLockPkg;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_WRDI    = 8'h04;
  localparam logic [7:0] OP_STATUS  = 8'h05;
  localparam logic [7:0] OP_LOCKWR  = 8'hE5;
  localparam logic [7:0] OP_OTPPROG = 8'h42;

  // Strobes from control to datapath, one system clock wide
  typedef struct packed {
    logic shiftEn;      // shift payload bit in
    logic shiftBit;     // the synchronized data bit
    logic loadStatus;   // load a fresh status byte
    logic shiftStatus;  // advance the status byte
    logic clearStatus;  // chip select idle
    logic doWren;
    logic doWrdi;
    logic doLock;       // well-formed lock frame ended
    logic doOtp;        // well-formed OTP frame ended
  } lockStrobes_t;

endpackage

// File: rtl/spiLockCtrl.sv
module spiLockCtrl
  import spiLockPkg::*;
#(
  parameter int FRAME_BITS = 40
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sckIn,
  input  logic         csNIn,
  input  logic         mosiIn,
  output lockStrobes_t strobes
);

  localparam int CNT_W = $clog2(FRAME_BITS) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] OPC_BITS = CNT_W'(8);
  localparam logic [CNT_W-1:0] FRM_BITS = CNT_W'(FRAME_BITS);

  logic [2:0]       sckSync;
  logic [2:0]       csSync;
  logic [1:0]       mosiSync;
  logic [CNT_W-1:0] bitCount;
  logic [7:0]       opcode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      csSync   <= '1;
      mosiSync <= '0;
    end else begin
      sckSync  <= {sckSync[1:0], sckIn};
      csSync   <= {csSync[1:0], csNIn};
      mosiSync <= {mosiSync[0], mosiIn};
    end
  end

  logic sckRise, sckFall, csIdle, csRise, dataBit;
  assign sckRise = sckSync[1] & ~sckSync[2];
  assign sckFall = ~sckSync[1] & sckSync[2];
  assign csIdle  = csSync[1];
  assign csRise  = csSync[1] & ~csSync[2];
  assign dataBit = mosiSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      opcode   <= '0;
    end else if (csIdle) begin
      bitCount <= '0;
      opcode   <= '0;
    end else if (sckRise) begin
      if (bitCount != CNT_MAX) bitCount <= bitCount + 1'b1;
      if (bitCount < OPC_BITS) opcode <= {opcode[6:0], dataBit};
    end
  end

  logic pastOpcode, isStatus;
  assign pastOpcode = bitCount >= OPC_BITS;
  assign isStatus   = pastOpcode && (opcode == OP_STATUS);

  always_comb begin
    strobes             = '0;
    strobes.shiftBit    = dataBit;
    strobes.shiftEn     = sckRise && !csIdle && pastOpcode && (bitCount != CNT_MAX);
    strobes.loadStatus  = sckFall && !csIdle && isStatus && (bitCount[2:0] == 3'd0);
    strobes.shiftStatus = sckFall && !csIdle && isStatus && (bitCount[2:0] != 3'd0);
    strobes.clearStatus = csIdle;
    strobes.doWren      = csRise && (bitCount == OPC_BITS) && (opcode == OP_WREN);
    strobes.doWrdi      = csRise && (bitCount == OPC_BITS) && (opcode == OP_WRDI);
    strobes.doLock      = csRise && (bitCount == FRM_BITS) && (opcode == OP_LOCKWR);
    strobes.doOtp       = csRise && (bitCount == FRM_BITS) && (opcode == OP_OTPPROG);
  end

  // R2 R5: at most one command ends per chip-select rise
  commit_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.doWren, strobes.doWrdi, strobes.doLock, strobes.doOtp}));

  // R5: the bit counter restarts whenever chip select was idle
  count_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(csIdle) |-> (bitCount == '0));

endmodule

// File: rtl/spiLockData.sv
module spiLockData
  import spiLockPkg::*;
#(
  parameter int ADDR_BITS  = 24,
  parameter int SECTORS    = 32,
  parameter int SECTOR_LSB = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busyIn,
  input  lockStrobes_t       strobes,
  output logic               misoOut,
  output logic [SECTORS-1:0] writeLockVec,
  output logic [SECTORS-1:0] lockDownVec,
  output logic [7:0]         otpCtrlOut,
  output logic               otpLockedOut
);

  localparam int PAYLOAD_BITS = ADDR_BITS + 8;
  localparam int SECTOR_BITS  = $clog2(SECTORS);
  localparam int SEL_POS      = 8 + SECTOR_LSB;

  logic [PAYLOAD_BITS-1:0] payload;
  logic                    wel;
  logic [3:0]              otpNib;
  logic [7:0]              statusShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) payload <= '0;
    else if (strobes.shiftEn) payload <= {payload[PAYLOAD_BITS-2:0], strobes.shiftBit};
  end

  logic [SECTOR_BITS-1:0] sectorSel;
  logic [7:0]             dataByte;
  logic                   lockOk, otpOk;
  assign sectorSel = payload[SEL_POS +: SECTOR_BITS];
  assign dataByte  = payload[7:0];
  assign lockOk    = strobes.doLock && wel && !busyIn;
  assign otpOk     = strobes.doOtp  && wel && !busyIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wel <= 1'b0;
    else if (strobes.doWren) wel <= 1'b1;
    else if (strobes.doWrdi || lockOk || otpOk) wel <= 1'b0;
  end

  for (genvar s = 0; s < SECTORS; s++) begin : gSector
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        writeLockVec[s] <= 1'b0;
        lockDownVec[s]  <= 1'b0;
      end else if (lockOk && (sectorSel == SECTOR_BITS'(s)) && !lockDownVec[s]) begin
        writeLockVec[s] <= dataByte[0];
        lockDownVec[s]  <= dataByte[1];
      end
    end

    // R8
    lockdown_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(lockDownVec[s]) |-> (lockDownVec[s] && $stable(writeLockVec[s])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) otpNib <= 4'hF;
    else if (otpOk) otpNib <= otpNib & dataByte[3:0];
  end

  assign otpCtrlOut   = {4'hF, otpNib};
  assign otpLockedOut = (otpNib == 4'h0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusShift <= '0;
    else if (strobes.clearStatus) statusShift <= '0;
    else if (strobes.loadStatus) statusShift <= {6'b0, wel, busyIn};
    else if (strobes.shiftStatus) statusShift <= {statusShift[6:0], 1'b0};
  end

  assign misoOut = statusShift[7];

  // R4
  bank_needs_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    ({writeLockVec, lockDownVec} != $past({writeLockVec, lockDownVec})) |-> $past(wel));

  // R7
  bank_busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busyIn) |-> ({writeLockVec, lockDownVec, otpNib} ==
                       $past({writeLockVec, lockDownVec, otpNib})));

  // R6
  wel_consumed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockOk || otpOk) |=> !wel);

  // R9
  otp_one_way_chk: assert property (@(posedge clk) disable iff (!rstN)
    (otpNib & ~$past(otpNib)) == 4'h0);

endmodule

// File: rtl/spiLockWriter.sv
module spiLockWriter
  import spiLockPkg::*;
#(
  parameter int ADDR_BITS  = 24,
  parameter int SECTORS    = 32,
  parameter int SECTOR_LSB = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sckIn,
  input  logic               csNIn,
  input  logic               mosiIn,
  input  logic               busyIn,
  output logic               misoOut,
  output logic [SECTORS-1:0] writeLockVec,
  output logic [SECTORS-1:0] lockDownVec,
  output logic [7:0]         otpCtrlOut,
  output logic               otpLockedOut
);

  localparam int FRAME_BITS = 8 + ADDR_BITS + 8;

  lockStrobes_t strobes;

  spiLockCtrl #(.FRAME_BITS(FRAME_BITS)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .sckIn   (sckIn),
    .csNIn   (csNIn),
    .mosiIn  (mosiIn),
    .strobes (strobes)
  );

  spiLockData #(
    .ADDR_BITS  (ADDR_BITS),
    .SECTORS    (SECTORS),
    .SECTOR_LSB (SECTOR_LSB)
  ) data_i (
    .clk          (clk),
    .rstN         (rstN),
    .busyIn       (busyIn),
    .strobes      (strobes),
    .misoOut      (misoOut),
    .writeLockVec (writeLockVec),
    .lockDownVec  (lockDownVec),
    .otpCtrlOut   (otpCtrlOut),
    .otpLockedOut (otpLockedOut)
  );

endmodule

// File: tb/spiLockWriter_tb_top.sv
module spiLockWriter_tb_top;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, csNIn = 1'b1, mosiIn = 1'b0, busyIn = 1'b0;
  logic misoOut, otpLockedOut;
  logic [31:0] writeLockVec, lockDownVec;
  logic [7:0] otpCtrlOut;

  always #2 clk = ~clk;

  spiLockWriter dut_i (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csNIn(csNIn), .mosiIn(mosiIn),
    .busyIn(busyIn), .misoOut(misoOut), .writeLockVec(writeLockVec),
    .lockDownVec(lockDownVec), .otpCtrlOut(otpCtrlOut), .otpLockedOut(otpLockedOut)
  );

  // Behavioural reference state
  logic [31:0] mWl = '0, mLd = '0;
  logic        mWel = 1'b0;
  logic [3:0]  mNib = 4'hF;

  int errors = 0, checks = 0;
  int cyc = 0;
  int settleUntil = 0;
  bit compareOn = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Per-clock comparison of the lock bank and OTP outputs (R1 R3 R8 R9 R10)
  always @(negedge clk) begin
    if (compareOn && rstN && cyc >= settleUntil) begin
      checks++;
      if (writeLockVec !== mWl || lockDownVec !== mLd ||
          otpCtrlOut !== {4'hF, mNib} || otpLockedOut !== (mNib == 4'h0)) begin
        errors++;
        $display("FAIL R3 R8 R9 R10 cyc=%0d: actual wl=%h ld=%h otp=%h ro=%b expected wl=%h ld=%h otp=%h ro=%b",
                 cyc, writeLockVec, lockDownVec, otpCtrlOut, otpLockedOut,
                 mWl, mLd, {4'hF, mNib}, (mNib == 4'h0));
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sckIn = 1'b0; mosiIn = b; waitClk(HALF);
    sckIn = 1'b1; waitClk(HALF);
  endtask

  task automatic frame(input logic [7:0] op, input logic [23:0] addr,
                       input logic [7:0] dat, input int nBits);
    logic [40:0] bits;
    logic [4:0]  sec;
    bits = {op, addr, dat, 1'b0};
    csNIn = 1'b0; waitClk(HALF);
    for (int i = 0; i < nBits; i++) sendBit(bits[40-i]);
    sckIn = 1'b0; waitClk(HALF);
    csNIn = 1'b1;
    // reference update at the chip-select rise
    if (nBits == 8 && op == 8'h06) mWel = 1'b1;
    if (nBits == 8 && op == 8'h04) mWel = 1'b0;
    if (nBits == 40 && (op == 8'hE5 || op == 8'h42) && mWel && !busyIn) begin
      if (op == 8'hE5) begin
        sec = addr[20:16];
        if (!mLd[sec]) begin
          mWl[sec] = dat[0];
          mLd[sec] = dat[1];
        end
      end else begin
        mNib = mNib & dat[3:0];
      end
      mWel = 1'b0;
    end
    settleUntil = cyc + 12;
    waitClk(3 * HALF);
  endtask

  task automatic statusRead(input int nBytes, input string tag);
    logic [7:0] got, exp;
    csNIn = 1'b0; waitClk(HALF);
    for (int i = 0; i < 8; i++) sendBit(logic'(8'h05 >> (7 - i)));
    for (int b = 0; b < nBytes; b++) begin
      exp = {6'b0, mWel, busyIn};
      for (int i = 0; i < 8; i++) begin
        sckIn = 1'b0; waitClk(HALF);
        got[7-i] = misoOut;
        sckIn = 1'b1; waitClk(HALF);
      end
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL R2 %s byte %0d: actual=%h expected=%h", tag, b, got, exp);
      end
    end
    sckIn = 1'b0; waitClk(HALF);
    csNIn = 1'b1; waitClk(3 * HALF);
  endtask

  task automatic wren();
    frame(8'h06, 24'h0, 8'h0, 8);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    compareOn = 1'b1;
    // R1 reset state
    statusRead(1, "R1 reset status");

    // R4: lock write without the latch does nothing
    frame(8'hE5, 24'h05_0000, 8'h03, 40);
    statusRead(1, "R4 latch still clear");

    // R2: set, clear, set
    wren();
    statusRead(1, "R2 after set");
    frame(8'h04, 24'h0, 8'h0, 8);
    statusRead(1, "R2 after clear");
    wren();

    // R3 R6: sector 3, other address bits arbitrary
    frame(8'hE5, 24'h03_ABCD, 8'h01, 40);
    statusRead(1, "R6 latch consumed");

    // R5: 39 and 41 bit frames are dropped, latch kept
    wren();
    frame(8'hE5, 24'h07_0000, 8'h01, 39);
    statusRead(1, "R5 after 39 bits");
    frame(8'hE5, 24'h07_0000, 8'h01, 41);
    frame(8'h42, 24'h0, 8'h00, 41);
    statusRead(1, "R5 after 41 bits");

    // R7: busy blocks the write, latch kept
    busyIn = 1'b1; waitClk(4);
    statusRead(1, "R7 busy status");
    frame(8'hE5, 24'h09_0000, 8'h01, 40);
    frame(8'h42, 24'h0, 8'h00, 40);
    busyIn = 1'b0; waitClk(4);
    statusRead(2, "R7 latch kept");

    // R8: lock-down freezes sector 31
    frame(8'hE5, 24'h1F_1234, 8'h03, 40);
    wren();
    frame(8'hE5, 24'h1F_0000, 8'h00, 40);
    statusRead(1, "R8 latch consumed");

    // R3: data bits 7:2 ignored, sector 0
    wren();
    frame(8'hE5, 24'h00_FFFF, 8'hFE, 40);
    // R3: sector field only, bits above 20 ignored
    wren();
    frame(8'hE5, 24'hE2_0000, 8'h01, 40);

    // R9: OTP nibble only clears
    wren();
    frame(8'h42, 24'h00_0040, 8'hF5, 40);
    wren();
    frame(8'h42, 24'h00_0000, 8'h0A, 40);
    wren();
    frame(8'h42, 24'h00_0000, 8'hFF, 40);
    statusRead(1, "R9 latch consumed");

    waitClk(20);
    compareOn = 1'b0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule